// File: doc/BRIEF.md
# Ticket Lock Controller

This block arbitrates one shared resource among a fixed set of requesters and serves them strictly in the order they arrive. It keeps two counters: a dispensing counter that hands each newly arriving requester its place in line, and a serving counter that names the place in line that currently owns the resource. A requester that raises its acquire line while it holds no ticket atomically receives the dispensing counter's value as its ticket, and the counter moves on. A requester owns the lock while its latched ticket equals the serving counter. A release by the owner advances the serving counter by one, so ownership passes to the next ticket in line.

Both counters run modulo 2^TKT_W and are compared only for equality, so wraparound needs no special handling as long as TKT_W is at least log2(N_REQ)+1. When several requesters arrive in the same cycle, the lowest index receives the lowest ticket. A release from a requester that does not own the lock changes nothing and raises an error pulse. The difference between the two counters is exported as the number of requesters holding tickets, which waiters can use to estimate how long they will wait.

Top module: `ticket_lock_ctrl`

## Requirements
- R1: After reset both counters are 0, no grant is high, queue_len_o is 0 and rel_err_o is 0.
- R2: On a clock edge where acq_i[i] is high and requester i holds no ticket, requester i latches the current dispensing value (offset by the number of such acquirers with a lower index in that cycle), and next_tkt_o advances by the number of such acquirers; acq_i from a requester already holding a ticket is ignored.
- R3: grant_o[i] is high exactly when requester i holds a ticket equal to serve_tkt_o; at most one grant bit is high, and an acquire into an empty queue is granted in the cycle after the edge that sampled it.
- R4: A release (rel_i[i] high while grant_o[i] is high) increments serve_tkt_o by one and frees requester i's ticket at that edge.
- R5: Requesters are granted in strict ticket order, i.e. first come first served, with same-cycle arrivals ordered by ascending index.
- R6: A release from a requester whose grant is low leaves both counters and all tickets unchanged, and rel_err_o is high for exactly the following cycle.
- R7: queue_len_o equals next_tkt_o minus serve_tkt_o modulo 2^TKT_W.
- R8: Both counters wrap from 2^TKT_W-1 to 0 and service order stays correct across the wrap.
- R9: A requester that owns the lock keeps its grant until it releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_i | input | N_REQ | Per-requester acquire request |
| rel_i | input | N_REQ | Per-requester release request |
| grant_o | output | N_REQ | Per-requester lock ownership |
| next_tkt_o | output | TKT_W | Dispensing counter (next ticket handed out) |
| serve_tkt_o | output | TKT_W | Serving counter (ticket that owns the lock) |
| queue_len_o | output | TKT_W | Number of requesters holding a ticket |
| rel_err_o | output | 1 | Pulse: a release arrived from a non-owner |

## Verification
The checker watches every cycle that at most one grant is high, that an owner keeps its grant until it releases, that the serving counter only ever stays or steps by one and steps exactly on a valid release, that the dispensing counter is still when nobody acquires, and that the error pulse follows a bad release and nothing else. Whether the ticket values themselves are right, that is same-cycle ordering by index, first-come-first-served hand-over across many waiters and correct service across counter wraparound, can only be shown by the bench's reference model, which tracks each requester's ticket and compares every output on every clock through directed and random scenarios.

// File: rtl/tkt_lock_pkg.sv
package tkt_lock_pkg;

   // Smallest counter width that keeps a full queue distinguishable from an empty one.
   function automatic int tkt_min_width(input int n_req);
      return $clog2(n_req) + 1;
   endfunction

endpackage

// File: rtl/tkt_dispenser.sv
module tkt_dispenser #(
   parameter int N_REQ = 4,
   parameter int TKT_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_REQ-1:0]              take_i,
   output logic [TKT_W-1:0]              next_o,
   output logic [N_REQ-1:0][TKT_W-1:0]   issue_o
);

   localparam int CW = $clog2(N_REQ + 1);

   logic [TKT_W-1:0] next_q;
   logic [CW-1:0]    total;

   // Each taker is offset by the takers of lower index in the same cycle.
   for (genvar i = 0; i < N_REQ; i++) begin : g_offs
      logic [CW-1:0] ahead;
      always_comb begin
         ahead = '0;
         for (int j = 0; j < i; j++) begin
            ahead = ahead + CW'(take_i[j]);
         end
         issue_o[i] = next_q + TKT_W'(ahead);
      end
   end

   always_comb begin
      total = '0;
      for (int j = 0; j < N_REQ; j++) begin
         total = total + CW'(take_i[j]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_q <= '0;
      end else begin
         next_q <= next_q + TKT_W'(total);
      end
   end

   assign next_o = next_q;

endmodule

// File: rtl/tkt_slot.sv
module tkt_slot #(
   parameter int TKT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic [TKT_W-1:0] tkt_i,
   input  logic             drop_i,
   input  logic [TKT_W-1:0] serve_i,
   output logic             held_o,
   output logic             grant_o
);

   logic             held_q;
   logic [TKT_W-1:0] tkt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         tkt_q  <= '0;
      end else if (drop_i) begin
         held_q <= 1'b0;
      end else if (take_i) begin
         held_q <= 1'b1;
         tkt_q  <= tkt_i;
      end
   end

   assign held_o  = held_q;
   assign grant_o = held_q && (tkt_q == serve_i);

endmodule

// File: rtl/tkt_serve_ctrl.sv
module tkt_serve_ctrl #(
   parameter int N_REQ = 4,
   parameter int TKT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_REQ-1:0]   rel_i,
   input  logic [N_REQ-1:0]   grant_i,
   output logic [TKT_W-1:0]   serve_o,
   output logic [N_REQ-1:0]   drop_o,
   output logic               rel_err_o
);

   logic [TKT_W-1:0] serve_q;
   logic             err_q;
   logic             advance;
   logic             bad;

   assign drop_o  = rel_i & grant_i;
   assign advance = |drop_o;
   assign bad     = |(rel_i & ~grant_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         serve_q <= '0;
         err_q   <= 1'b0;
      end else begin
         serve_q <= serve_q + TKT_W'(advance);
         err_q   <= bad;
      end
   end

   assign serve_o   = serve_q;
   assign rel_err_o = err_q;

endmodule

// File: rtl/ticket_lock_ctrl.sv
module ticket_lock_ctrl #(
   parameter int N_REQ = 4,
   parameter int TKT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_REQ-1:0]   acq_i,
   input  logic [N_REQ-1:0]   rel_i,
   output logic [N_REQ-1:0]   grant_o,
   output logic [TKT_W-1:0]   next_tkt_o,
   output logic [TKT_W-1:0]   serve_tkt_o,
   output logic [TKT_W-1:0]   queue_len_o,
   output logic               rel_err_o
);

   import tkt_lock_pkg::*;

   if (N_REQ < 1) begin : g_bad_n
      $error("ticket_lock_ctrl: N_REQ must be at least 1");
   end
   if (TKT_W < tkt_min_width(N_REQ)) begin : g_bad_w
      $error("ticket_lock_ctrl: TKT_W too narrow for N_REQ");
   end

   logic [N_REQ-1:0]            held;
   logic [N_REQ-1:0]            take;
   logic [N_REQ-1:0]            drop;
   logic [N_REQ-1:0][TKT_W-1:0] issue;
   logic [TKT_W-1:0]            next_q;
   logic [TKT_W-1:0]            serve_q;

   assign take = acq_i & ~held;

   tkt_dispenser #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_disp (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .next_o  (next_q),
      .issue_o (issue)
   );

   for (genvar i = 0; i < N_REQ; i++) begin : g_slot
      tkt_slot #(.TKT_W(TKT_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .take_i  (take[i]),
         .tkt_i   (issue[i]),
         .drop_i  (drop[i]),
         .serve_i (serve_q),
         .held_o  (held[i]),
         .grant_o (grant_o[i])
      );
   end

   tkt_serve_ctrl #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_serve (
      .clk       (clk),
      .rst_n     (rst_n),
      .rel_i     (rel_i),
      .grant_i   (grant_o),
      .serve_o   (serve_q),
      .drop_o    (drop),
      .rel_err_o (rel_err_o)
   );

   assign next_tkt_o  = next_q;
   assign serve_tkt_o = serve_q;
   assign queue_len_o = next_q - serve_q;

endmodule

// File: rtl/tkt_lock_chk.sv
module tkt_lock_chk #(
   parameter int N_REQ = 4,
   parameter int TKT_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_REQ-1:0]   acq_i,
   input logic [N_REQ-1:0]   rel_i,
   input logic [N_REQ-1:0]   grant_o,
   input logic [TKT_W-1:0]   next_tkt_o,
   input logic [TKT_W-1:0]   serve_tkt_o,
   input logic [TKT_W-1:0]   queue_len_o,
   input logic               rel_err_o
);

   // R3: a single owner at any time
   a_r3_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R4: a valid release steps the serving counter by exactly one
   a_r4_release_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rel_i & grant_o)) |=> (serve_tkt_o == TKT_W'($past(serve_tkt_o) + 1'b1)));

   // R4, R6: without a valid release the serving counter holds
   a_r6_serve_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(rel_i & grant_o)) |=> $stable(serve_tkt_o));

   // R6: a bad release is flagged in the next cycle
   a_r6_bad_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rel_i & ~grant_o)) |=> rel_err_o);

   // R6: the flag has no other cause
   a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(rel_i & ~grant_o)) |=> !rel_err_o);

   // R2: dispensing counter is still without acquires
   a_r2_next_still: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_i == '0) |=> $stable(next_tkt_o));

   // R7: the queue never holds more than one ticket per requester
   a_r7_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(queue_len_o) <= N_REQ);

   // R9: an owner keeps the lock until it releases
   for (genvar i = 0; i < N_REQ; i++) begin : g_keep
      a_r9_keep_grant: assert property (@(posedge clk) disable iff (!rst_n)
         (grant_o[i] && !rel_i[i]) |=> grant_o[i]);
   end

endmodule

bind ticket_lock_ctrl tkt_lock_chk #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acq_i       (acq_i),
   .rel_i       (rel_i),
   .grant_o     (grant_o),
   .next_tkt_o  (next_tkt_o),
   .serve_tkt_o (serve_tkt_o),
   .queue_len_o (queue_len_o),
   .rel_err_o   (rel_err_o)
);

// File: tb/ticket_lock_ctrl_bench.sv
module ticket_lock_ctrl_bench;

   localparam int N   = 4;
   localparam int W   = 3;
   localparam int MOD = 1 << W;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   acq_i = '0;
   logic [N-1:0]   rel_i = '0;
   logic [N-1:0]   grant_o;
   logic [W-1:0]   next_tkt_o;
   logic [W-1:0]   serve_tkt_o;
   logic [W-1:0]   queue_len_o;
   logic           rel_err_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // reference model state
   int m_tkt  [N];
   bit m_held [N];
   int m_next  = 0;
   int m_serve = 0;
   bit m_err   = 0;

   always #10 clk = ~clk;

   ticket_lock_ctrl #(.N_REQ(N), .TKT_W(W)) u_ticket_lock_ctrl (
      .clk (clk), .rst_n (rst_n), .acq_i (acq_i), .rel_i (rel_i),
      .grant_o (grant_o), .next_tkt_o (next_tkt_o), .serve_tkt_o (serve_tkt_o),
      .queue_len_o (queue_len_o), .rel_err_o (rel_err_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int owner();
      for (int i = 0; i < N; i++)
         if (m_held[i] && m_tkt[i] == m_serve) return i;
      return -1;
   endfunction

   function automatic int exp_grants();
      int g = 0;
      for (int i = 0; i < N; i++)
         if (m_held[i] && m_tkt[i] == m_serve) g |= (1 << i);
      return g;
   endfunction

   task automatic model_step(input logic [N-1:0] a, input logic [N-1:0] r);
      bit held_pre [N];
      int own = owner();
      bit adv = 0;
      m_err = 0;
      for (int i = 0; i < N; i++) held_pre[i] = m_held[i];
      for (int i = 0; i < N; i++) begin
         if (r[i]) begin
            if (i == own) begin adv = 1; m_held[i] = 0; end
            else m_err = 1;
         end
      end
      for (int i = 0; i < N; i++) begin
         if (a[i] && !held_pre[i]) begin
            m_tkt[i]  = m_next;
            m_held[i] = 1;
            m_next    = (m_next + 1) % MOD;
         end
      end
      if (adv) m_serve = (m_serve + 1) % MOD;
   endtask

   task automatic compare();
      chk("R3 R5 grant", int'(grant_o), exp_grants());
      chk("R2 next ticket", int'(next_tkt_o), m_next);
      chk("R4 serve ticket", int'(serve_tkt_o), m_serve);
      chk("R7 queue length", int'(queue_len_o), (m_next - m_serve + MOD) % MOD);
      chk("R6 release error", int'(rel_err_o), int'(m_err));
   endtask

   task automatic cyc(input logic [N-1:0] a, input logic [N-1:0] r);
      @(negedge clk);
      acq_i = a;
      rel_i = r;
      model_step(a, r);
      @(posedge clk);
      #5;
      compare();
   endtask

   task automatic rel_owner();
      int o = owner();
      cyc('0, (o >= 0) ? N'(1 << o) : '0);
   endtask

   initial begin : watchdog
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      int wrap_seen;
      for (int i = 0; i < N; i++) begin m_tkt[i] = 0; m_held[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 reset grant", int'(grant_o), 0);
      chk("R1 reset next", int'(next_tkt_o), 0);
      chk("R1 reset serve", int'(serve_tkt_o), 0);
      chk("R1 reset queue", int'(queue_len_o), 0);
      chk("R1 reset err", int'(rel_err_o), 0);

      // R3: lone acquire is granted next cycle, then released
      cyc(4'b0100, '0);
      chk("R3 lone grant", int'(grant_o), 4'b0100);
      cyc('0, 4'b0100);

      // R2 R5: all arrive together, lowest index served first
      cyc(4'b1111, '0);
      chk("R5 same-cycle first", int'(grant_o), 4'b0001);
      rel_owner();
      chk("R5 same-cycle second", int'(grant_o), 4'b0010);
      rel_owner();
      rel_owner();
      rel_owner();

      // R5: staggered arrivals 2, 0, 3, 1
      cyc(4'b0100, '0);
      cyc(4'b0001, '0);
      cyc(4'b1000, '0);
      cyc(4'b0010, '0);
      rel_owner();
      chk("R5 staggered second", int'(grant_o), 4'b0001);
      rel_owner();
      chk("R5 staggered third", int'(grant_o), 4'b1000);

      // R6: waiter and idle release are ignored and flagged
      cyc('0, 4'b0010);
      chk("R6 waiter release flag", int'(rel_err_o), 1);
      cyc('0, '0);
      chk("R6 flag one cycle", int'(rel_err_o), 0);
      rel_owner();
      rel_owner();
      cyc('0, 4'b0100);

      // R2: re-acquire while holding is ignored
      cyc(4'b0011, '0);
      cyc(4'b0011, '0);
      chk("R2 re-acquire ignored", int'(queue_len_o), 2);
      rel_owner();
      rel_owner();

      // R8: many rounds across the wrap
      wrap_seen = 0;
      for (int k = 0; k < 6; k++) begin
         cyc(4'b1011, '0);
         cyc(4'b0100, '0);
         for (int j = 0; j < 4; j++) begin
            rel_owner();
            if (serve_tkt_o == '0) wrap_seen = 1;
         end
      end
      chk("R8 serve wrapped", wrap_seen, 1);

      // R9 and mixed traffic: random acquires, owner releases, stray releases
      for (int k = 0; k < 3000; k++) begin
         logic [N-1:0] a;
         logic [N-1:0] r;
         int o;
         a = N'($urandom);
         if (($urandom % 3) != 0) a = '0;
         o = owner();
         r = '0;
         if (o >= 0 && ($urandom % 4) == 0) r = N'(1 << o);
         if (($urandom % 23) == 0) r = r | N'(1 << ($urandom % N));
         cyc(a, r);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule